// File: doc/BRIEF.md
# Detector Channel Preprocessor and Packer

This block takes one trigger's worth of samples from a frontend chip that reads out 128 channels, processes them, and packs the result into 32-bit data words. Samples arrive as a stream of channel index plus 12-bit ADC value and are stored in an event buffer. Two software-loaded per-channel tables sit beside the buffer: a pedestal table and a threshold table. A start strobe carries a 3-bit opcode, which selects one of eight processing modes. The block then scans the buffer in ascending channel order. Words that survive the mode's selection are emitted on a valid/ready stream, and the final word carries a last flag.

Even channels are physical detector channels. Each odd channel is an auxiliary channel paired with the even channel below it, and it gives that channel its local baseline. The baseline-corrected value of even channel 2k is (s[2k] − ped[2k]) − (s[2k+1] − ped[2k+1]) + 0x2000. The pedestal-corrected value of channel c is s[c] − ped[c] + 0x2000. Both results are saturated to the range 0..0x3FFF.

Top module: `chanPacker`

## Requirements
- R1: Every data word has bit 31 = 0, and holds the sector ID in bits 30:28, the module ID in 27:25, the chip ID in 24:21, the channel in 20:14 and the 14-bit value in 13:0.
- R2: Opcode 0 emits all 128 channels in ascending order, each with its raw sample zero-extended to 14 bits.
- R3: Opcode 1 emits all 128 channels, each with its pedestal-corrected value.
- R4: Opcode 2 emits, in ascending order, only the channels whose pedestal-corrected value is strictly greater than 0x2000 + threshold[c].
- R5: Opcode 3 emits no words. It ends the event with the empty-event done pulse.
- R6: Opcode 4 emits 128 words. Even channels carry their baseline-corrected value and odd channels carry their pedestal-corrected value.
- R7: Opcode 5 emits the 64 even channels, each with its baseline-corrected value.
- R8: Opcode 6 works like opcode 5, but drops an even channel when its own raw sample or its odd partner's raw sample is 0x000 or 0xFFF, or when the result saturates.
- R9: Opcode 7 works like opcode 5, but keeps only the even channels whose baseline-corrected value is strictly greater than 0x2000 + threshold of that even channel.
- R10: The last flag is set on the final word of an event and on no other word. An event with no surviving words raises `evtDone` for exactly one cycle and emits no words.
- R11: While `outValid` is high and `outReady` is low, `outData` and `outLast` hold their values. No word is lost or duplicated under backpressure.
- R12: While `busy` is high, start strobes and sample writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Write one sample into the event buffer |
| sampleChan | input | 7 | Channel index of the sample |
| sampleAdc | input | 12 | Raw ADC value |
| startValid | input | 1 | Begin processing the buffered event |
| startOp | input | 3 | Processing mode for this event |
| sectorId | input | 3 | Static sector number |
| moduleId | input | 3 | Static module number |
| chipId | input | 4 | Static frontend chip number |
| cfgWrEn | input | 1 | Table write strobe |
| cfgSel | input | 1 | 0 selects the pedestal table, 1 selects the threshold table |
| cfgAddr | input | 7 | Table channel index |
| cfgData | input | 12 | Table entry value |
| outReady | input | 1 | Downstream accepts the word |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Packed output word |
| outLast | output | 1 | Final word of the event |
| evtDone | output | 1 | One-cycle pulse for an event with no words |
| busy | output | 1 | Event in progress or output word pending |

## Verification
The hardest case to reach is a stall that arrives just as the scan hands a held-back word to the output register. If the last flag or a word is lost there, the fault shows only with sparse selections, such as the threshold modes, combined with an irregular ready pattern. The bench meets this by mixing random ready duty cycles with random opcodes, random tables and random samples. It also forces directed boundary events: a threshold one code below and one code above the pass level, pinned 0x000/0xFFF samples for the drop mode, and an event in which nothing survives. A further case checks that a write made while the block is busy left the buffer untouched, by re-running a raw event without reloading the samples.

// File: rtl/chanPacker_pkg.sv
package chanPacker_pkg;

  typedef enum logic [2:0] {
    OP_RAW      = 3'd0,
    OP_PED      = 3'd1,
    OP_PEDTHR   = 3'd2,
    OP_RSVD     = 3'd3,
    OP_MIXED    = 3'd4,
    OP_BASE     = 3'd5,
    OP_BASEGOOD = 3'd6,
    OP_BASETHR  = 3'd7
  } procOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;    // latch the event opcode
    logic capture;   // current candidate becomes the held word
    logic push;      // held word moves to the output register
    logic lastFlag;  // pushed word closes the event
  } ctlStrobe_t;

endpackage

// File: rtl/chanPackerPath.sv
module chanPackerPath
  import chanPacker_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int ADC_W  = 12,
  parameter int VAL_W  = 14,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [CH_W-1:0]  sampleChan,
  input  logic [ADC_W-1:0] sampleAdc,
  input  logic             busy,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CH_W-1:0]  cfgAddr,
  input  logic [ADC_W-1:0] cfgData,
  input  logic [2:0]       startOp,
  input  ctlStrobe_t       strobe,
  input  logic [CH_W-1:0]  idx,
  input  logic [2:0]       sectorId,
  input  logic [2:0]       moduleId,
  input  logic [3:0]       chipId,
  input  logic             outReady,
  output logic             candKeep,
  output logic             evenOnly,
  output logic             outValid,
  output logic [31:0]      outData,
  output logic             outLast
);

  localparam int SUM_W = VAL_W + 2;
  localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(1 << (VAL_W - 1));
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << VAL_W) - 1);

  logic [ADC_W-1:0] sampleMem [NUM_CH];
  logic [ADC_W-1:0] pedMem    [NUM_CH];
  logic [ADC_W-1:0] thrMem    [NUM_CH];
  procOp_e          opReg;
  logic [31:0]      pendWord;

  function automatic logic signed [SUM_W-1:0] ext(input logic [ADC_W-1:0] a);
    return signed'({{(SUM_W-ADC_W){1'b0}}, a});
  endfunction

  // returns {saturated, value}
  function automatic logic [VAL_W:0] satVal(input logic signed [SUM_W-1:0] x);
    if (x < 0)          return {1'b1, {VAL_W{1'b0}}};
    else if (x > MAX_S) return {1'b1, {VAL_W{1'b1}}};
    else                return {1'b0, x[VAL_W-1:0]};
  endfunction

  function automatic logic aboveThr(input logic [VAL_W-1:0] v, input logic [ADC_W-1:0] t);
    return SUM_W'(v) > (SUM_W'(MID_S) + SUM_W'(t));
  endfunction

  always_ff @(posedge clk) begin
    if (sampleValid && !busy) sampleMem[sampleChan] <= sampleAdc;
    if (cfgWrEn && !cfgSel)   pedMem[cfgAddr] <= cfgData;
    if (cfgWrEn &&  cfgSel)   thrMem[cfgAddr] <= cfgData;
  end

  logic [CH_W-1:0]  evenCh, oddCh;
  logic [ADC_W-1:0] sEven, sOdd;
  logic [VAL_W:0]   pedRes, baseRes;
  logic             badRaw;
  logic [VAL_W-1:0] candVal;

  always_comb begin
    evenCh  = {idx[CH_W-1:1], 1'b0};
    oddCh   = {idx[CH_W-1:1], 1'b1};
    sEven   = sampleMem[evenCh];
    sOdd    = sampleMem[oddCh];
    pedRes  = satVal(ext(sampleMem[idx]) - ext(pedMem[idx]) + MID_S);
    baseRes = satVal(ext(sEven) - ext(pedMem[evenCh]) - ext(sOdd) + ext(pedMem[oddCh]) + MID_S);
    badRaw  = (sEven == '0) || (sEven == '1) || (sOdd == '0) || (sOdd == '1) || baseRes[VAL_W];
    candVal  = '0;
    candKeep = 1'b0;
    unique case (opReg)
      OP_RAW:      begin candVal = VAL_W'(sampleMem[idx]); candKeep = 1'b1; end
      OP_PED:      begin candVal = pedRes[VAL_W-1:0]; candKeep = 1'b1; end
      OP_PEDTHR:   begin
        candVal  = pedRes[VAL_W-1:0];
        candKeep = aboveThr(pedRes[VAL_W-1:0], thrMem[idx]);
      end
      OP_RSVD:     begin candVal = '0; candKeep = 1'b0; end
      OP_MIXED:    begin
        candVal  = idx[0] ? pedRes[VAL_W-1:0] : baseRes[VAL_W-1:0];
        candKeep = 1'b1;
      end
      OP_BASE:     begin candVal = baseRes[VAL_W-1:0]; candKeep = 1'b1; end
      OP_BASEGOOD: begin candVal = baseRes[VAL_W-1:0]; candKeep = !badRaw; end
      OP_BASETHR:  begin
        candVal  = baseRes[VAL_W-1:0];
        candKeep = aboveThr(baseRes[VAL_W-1:0], thrMem[evenCh]);
      end
      default:     begin candVal = '0; candKeep = 1'b0; end
    endcase
    evenOnly = opReg[2] && (opReg[1:0] != 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_RSVD;
      pendWord <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else begin
      if (strobe.loadOp)  opReg <= procOp_e'(startOp);
      if (strobe.capture) pendWord <= {1'b0, sectorId, moduleId, chipId, 7'(idx), candVal};
      if (strobe.push) begin
        outValid <= 1'b1;
        outData  <= pendWord;
        outLast  <= strobe.lastFlag;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/chanPackerCtrl.sv
module chanPackerCtrl
  import chanPacker_pkg::*;
#(
  parameter int NUM_CH = 128,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [2:0]      startOp,
  input  logic            candKeep,
  input  logic            evenOnly,
  input  logic            outValid,
  input  logic            outReady,
  output ctlStrobe_t      strobe,
  output logic [CH_W-1:0] idx,
  output logic            busy,
  output logic            evtDone
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FLUSH} ctlState_e;

  ctlState_e state;
  logic      pendValid;
  logic      outFree, startOk, endNow, advance;

  always_comb begin
    outFree = !outValid || outReady;
    busy    = (state != S_IDLE) || outValid;
    startOk = (state == S_IDLE) && startValid && !outValid;
    endNow  = evenOnly ? (idx == CH_W'(NUM_CH - 2)) : (idx == CH_W'(NUM_CH - 1));
    advance = !candKeep || !pendValid || outFree;
    strobe  = '0;
    unique case (state)
      S_IDLE:  strobe.loadOp = startOk;
      S_SCAN: begin
        strobe.capture = candKeep && advance;
        strobe.push    = candKeep && pendValid && outFree;
      end
      S_FLUSH: begin
        strobe.push     = pendValid && outFree;
        strobe.lastFlag = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      idx       <= '0;
      pendValid <= 1'b0;
      evtDone   <= 1'b0;
    end else begin
      evtDone <= 1'b0;
      unique case (state)
        S_IDLE: if (startOk) begin
          idx       <= '0;
          pendValid <= 1'b0;
          state     <= (startOp == OP_RSVD) ? S_FLUSH : S_SCAN;
        end
        S_SCAN: if (advance) begin
          if (candKeep) pendValid <= 1'b1;
          idx <= idx + (evenOnly ? CH_W'(2) : CH_W'(1));
          if (endNow) state <= S_FLUSH;
        end
        S_FLUSH: begin
          if (!pendValid) begin
            evtDone <= 1'b1;
            state   <= S_IDLE;
          end else if (outFree) begin
            pendValid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chanPacker.sv
module chanPacker
  import chanPacker_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int ADC_W  = 12,
  parameter int VAL_W  = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [6:0]  sampleChan,
  input  logic [11:0] sampleAdc,
  input  logic        startValid,
  input  logic [2:0]  startOp,
  input  logic [2:0]  sectorId,
  input  logic [2:0]  moduleId,
  input  logic [3:0]  chipId,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [6:0]  cfgAddr,
  input  logic [11:0] cfgData,
  input  logic        outReady,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        outLast,
  output logic        evtDone,
  output logic        busy
);

  ctlStrobe_t  strobe;
  logic [6:0]  idx;
  logic        candKeep, evenOnly;

  chanPackerCtrl #(.NUM_CH(NUM_CH)) ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .candKeep(candKeep), .evenOnly(evenOnly), .outValid(outValid),
    .outReady(outReady), .strobe(strobe), .idx(idx), .busy(busy),
    .evtDone(evtDone)
  );

  chanPackerPath #(.NUM_CH(NUM_CH), .ADC_W(ADC_W), .VAL_W(VAL_W)) path (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleAdc(sampleAdc), .busy(busy), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .startOp(startOp), .strobe(strobe),
    .idx(idx), .sectorId(sectorId), .moduleId(moduleId), .chipId(chipId),
    .outReady(outReady), .candKeep(candKeep), .evenOnly(evenOnly),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

endmodule

// File: rtl/chanPacker_chk.sv
module chanPacker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outLast,
  input logic        evtDone,
  input logic [2:0]  sectorId,
  input logic [2:0]  moduleId,
  input logic [3:0]  chipId
);

  logic       havePrev;
  logic [6:0] prevChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      havePrev <= 1'b0;
      prevChan <= '0;
    end else if (outValid && outReady) begin
      havePrev <= !outLast;
      prevChan <= outData[20:14];
    end
  end

  assert_word_ids_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData[31] == 1'b0) && (outData[30:21] == {sectorId, moduleId, chipId}));

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && havePrev) |-> (outData[20:14] > prevChan));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |=> !evtDone);

  assert_done_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |-> !outValid);

endmodule

bind chanPacker chanPacker_chk chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast), .evtDone(evtDone),
  .sectorId(sectorId), .moduleId(moduleId), .chipId(chipId)
);

// File: tb/chanPacker_test.sv
`timescale 1ns/1ps
module chanPacker_test;

  localparam logic [2:0] SEC  = 3'd5;
  localparam logic [2:0] MODN = 3'd2;
  localparam logic [3:0] CHIP = 4'd11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [6:0]  sampleChan = '0;
  logic [11:0] sampleAdc = '0;
  logic        startValid = 1'b0;
  logic [2:0]  startOp = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [11:0] cfgData = '0;
  logic        outReady = 1'b0;
  logic        outValid, outLast, evtDone, busy;
  logic [31:0] outData;

  always #4 clk = ~clk;

  chanPacker uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleAdc(sampleAdc), .startValid(startValid), .startOp(startOp),
    .sectorId(SEC), .moduleId(MODN), .chipId(CHIP), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .evtDone(evtDone), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  int smp [128];
  int ped [128];
  int thr [128];
  logic [31:0] expW [128];
  int expN;
  logic [31:0] recW [256];
  int recN;
  bit recLast, sawDone;
  string opTag [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9"};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampV(input int v);
    if (v < 0) return 0;
    if (v > 16383) return 16383;
    return v;
  endfunction

  function automatic int pedV(input int c);
    return clampV(smp[c] - ped[c] + 8192);
  endfunction

  function automatic int baseV(input int c);
    return clampV((smp[c] - ped[c]) - (smp[c+1] - ped[c+1]) + 8192);
  endfunction

  function automatic bit badPair(input int c);
    int raw = (smp[c] - ped[c]) - (smp[c+1] - ped[c+1]) + 8192;
    return smp[c] == 0 || smp[c] == 4095 || smp[c+1] == 0 || smp[c+1] == 4095 ||
           raw < 0 || raw > 16383;
  endfunction

  function automatic void addExp(input int c, input int v);
    expW[expN] = {1'b0, SEC, MODN, CHIP, 7'(c), 14'(v)};
    expN++;
  endfunction

  function automatic void buildExp(input int op);
    expN = 0;
    for (int c = 0; c < 128; c++) begin
      case (op)
        0: addExp(c, smp[c]);
        1: addExp(c, pedV(c));
        2: if (pedV(c) > 8192 + thr[c]) addExp(c, pedV(c));
        4: addExp(c, (c % 2 == 0) ? baseV(c) : pedV(c));
        5: if (c % 2 == 0) addExp(c, baseV(c));
        6: if (c % 2 == 0 && !badPair(c)) addExp(c, baseV(c));
        7: if (c % 2 == 0 && baseV(c) > 8192 + thr[c]) addExp(c, baseV(c));
        default: ;
      endcase
    end
  endfunction

  task automatic loadSamples();
    for (int c = 0; c < 128; c++) begin
      @(negedge clk);
      sampleValid = 1'b1; sampleChan = 7'(c); sampleAdc = 12'(smp[c]);
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic loadTables();
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      cfgWrEn = 1'b1; cfgSel = c[7]; cfgAddr = 7'(c);
      cfgData = c[7] ? 12'(thr[c % 128]) : 12'(ped[c % 128]);
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // start an event and gather its words; readyPct is the ready duty in percent
  task automatic collect(input int op, input int readyPct);
    recN = 0; recLast = 0; sawDone = 0;
    @(negedge clk);
    startValid = 1'b1; startOp = 3'(op);
    @(negedge clk);
    startValid = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      outReady = ($urandom % 100) < readyPct;
      if (evtDone) begin sawDone = 1; break; end
      if (outValid && outReady) begin
        recW[recN] = outData;
        recN++;
        if (outLast) begin recLast = 1; break; end
      end
    end
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic compareEvent(input string tag);
    check(recN == expN, tag, 32'(recN), 32'(expN));
    for (int i = 0; i < recN && i < expN; i++)
      check(recW[i] == expW[i], tag, recW[i], expW[i]);
    if (expN > 0) begin
      check(recLast && !sawDone, "R10", 32'(recLast), 32'd1);
      check(recW[0][31:21] == {1'b0, SEC, MODN, CHIP}, "R1", 32'(recW[0][31:21]),
            32'({1'b0, SEC, MODN, CHIP}));
    end else begin
      check(sawDone && recN == 0, "R10", 32'(sawDone), 32'd1);
    end
  endtask

  task automatic runEvent(input int op, input int readyPct, input string tag);
    buildExp(op);
    collect(op, readyPct);
    compareEvent(tag);
  endtask

  task automatic randomFill();
    for (int c = 0; c < 128; c++) begin
      smp[c] = 1 + ($urandom % 4094);
      ped[c] = $urandom % 1024;
      thr[c] = $urandom % 2048;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!outValid && !evtDone && !busy, "R10", {29'd0, outValid, evtDone, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: every opcode on random data, full ready
    randomFill();
    loadTables();
    loadSamples();
    for (int op = 0; op < 8; op++) runEvent(op, 100, opTag[op]);

    // R11: heavy backpressure on dense and sparse modes
    runEvent(0, 30, "R11");
    runEvent(2, 25, "R11");
    runEvent(7, 40, "R11");

    // R4 boundary: value exactly at the level fails, one above passes
    for (int c = 0; c < 128; c++) begin ped[c] = 0; thr[c] = 100; smp[c] = 100; end
    smp[10] = 101; smp[77] = 4095; smp[40] = 99;
    loadTables();
    loadSamples();
    runEvent(2, 70, "R4");
    // R9 empty: pairs equal -> 0x2000, never above level; R10 done pulse
    for (int c = 0; c < 128; c++) smp[c] = 500;
    loadSamples();
    runEvent(7, 100, "R9");
    runEvent(3, 100, "R5");

    // R8: pinned extreme samples on both sides of pairs
    randomFill();
    smp[0] = 0; smp[5] = 4095; smp[20] = 4095; smp[33] = 0; smp[126] = 0;
    loadTables();
    loadSamples();
    runEvent(6, 80, "R8");

    // R12: start and sample write while busy are ignored
    buildExp(0);
    fork
      collect(0, 100);
      begin
        repeat (10) @(negedge clk);
        startValid = 1'b1; startOp = 3'd3;
        sampleValid = 1'b1; sampleChan = 7'd5; sampleAdc = 12'(~smp[5]);
        @(negedge clk);
        startValid = 1'b0; sampleValid = 1'b0;
      end
    join
    compareEvent("R12");
    begin
      bit stray = 0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (outValid || evtDone) stray = 1;
      end
      check(!stray, "R12", 32'(stray), 32'd0);
    end
    runEvent(0, 100, "R12");

    // constrained random events
    for (int e = 0; e < 12; e++) begin
      int op;
      randomFill();
      if (e % 3 == 0) smp[2 * ($urandom % 64)] = 4095 * ($urandom % 2);
      loadTables();
      loadSamples();
      op = $urandom % 8;
      runEvent(op, 20 + ($urandom % 81), opTag[op]);
    end

    summary();
    $finish;
  end

endmodule